// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the modem-status view of a serial port. It watches four incoming handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. It holds their present levels and one sticky change flag per line in an 8-bit status word. A status-change interrupt request is raised while any change flag is set and the interrupt is enabled. The external lines are active-low. Each line passes through a synchronizer before it is compared with the level stored in the previous cycle.

A bus front end reads the status word through a one-cycle read strobe. That read clears all four change flags. The block also takes the modem-control byte. Its low four bits drive the four active-low handshake outputs. When bit 4 of that byte is set, the block enters self-test loopback. In loopback the outgoing control bits are routed back in place of the external lines, the external lines are ignored, and the outputs sit at their inactive (high) level.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status word reads 0x00, the interrupt request is low and all four handshake outputs are high.
- R2: The status word holds the line levels in its upper nibble: bit 4 clear-to-send, bit 5 data-set-ready, bit 6 ring, bit 7 carrier. It holds the change flags in its lower nibble: bit 0 clear-to-send changed, bit 1 data-set-ready changed, bit 2 ring trailing edge, bit 3 carrier changed.
- R3: The external lines are active-low: a low pin reads as level 1. A pin change reaches the status word after the third rising clock edge following it, and not before.
- R4: While control bit 4 is 1, the level bits follow the control bits one clock later, with this mapping: bit 1 to clear-to-send, bit 0 to data-set-ready, bit 2 to ring, bit 3 to carrier. The external pins then have no effect on the status word.
- R5: Outside loopback, each handshake output is the inverse of its control bit: data-terminal-ready from bit 0, request-to-send from bit 1, aux1 from bit 2, aux2 from bit 3. In loopback all four outputs are high.
- R6: The clear-to-send, data-set-ready and carrier change flags set on a level change in either direction.
- R7: The ring flag (bit 2) sets only when the ring level goes from 1 to 0. A rise of the ring level sets no flag and raises no interrupt.
- R8: Change flags stay set until a read. A read strobe returns the current word and clears all four flags at that clock edge, so a second read returns only the levels. A change that lands in the same cycle as the read still sets its flag.
- R9: The interrupt request is high exactly while the enable input is 1 and at least one change flag is set. A read removes it.
- R10: In loopback, dropping all four control bits in one write sets the clear-to-send, data-set-ready and carrier flags together. The ring flag sets as well only if ring was at level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mcr_i | input | 8 | Modem-control byte: bits 0..3 control outputs, bit 4 loopback |
| ms_irq_en_i | input | 1 | Modem-status interrupt enable |
| cts_n_i | input | 1 | Clear-to-send pin, active-low |
| dsr_n_i | input | 1 | Data-set-ready pin, active-low |
| ri_n_i | input | 1 | Ring indicator pin, active-low |
| dcd_n_i | input | 1 | Carrier detect pin, active-low |
| status_rd_i | input | 1 | One-cycle read strobe for the status word |
| status_o | output | 8 | Status word: levels in 7:4, change flags in 3:0 |
| ms_irq_o | output | 1 | Modem-status interrupt request |
| dtr_n_o | output | 1 | Data-terminal-ready output, active-low |
| rts_n_o | output | 1 | Request-to-send output, active-low |
| out1_n_o | output | 1 | Auxiliary output 1, active-low |
| out2_n_o | output | 1 | Auxiliary output 2, active-low |

## Verification
The assertions check four properties on every cycle. Change flags stay set without a read. A read with no coinciding change leaves all flags clear. The ring flag never sets while the ring level was 0. In loopback the level bits track the control bits one clock later. They also tie the interrupt request to the enable and to a non-empty flag nibble.

The bench scenarios cover the rest. These are the three-edge latency of the pin synchronizer, the exact bit positions of each line, and the ring flag on its trailing edge. They also cover the combined flags from dropping all control bits at once, and a read colliding with a new change.

// File: rtl/modem_stat_pkg.sv
`timescale 1ns/1ps
package modem_stat_pkg;
  localparam int NLINES = 4;
  localparam int STAT_W = 2 * NLINES;

  // line index inside the level / flag nibbles
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;

  // modem-control byte bit positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_OUT2 = 3;
  localparam int MC_LOOP = 4;

  typedef logic [NLINES-1:0] lines_t;
endpackage

// File: rtl/modem_sync.sv
`timescale 1ns/1ps
module modem_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (s == 0) begin : g_first
        assign src = d_i;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
        else        stage_q[s] <= src;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/modem_line_sel.sv
`timescale 1ns/1ps
module modem_line_sel
  import modem_stat_pkg::*;
(
  input  logic   loop_i,
  input  lines_t ctl_i,       // control bits 0..3 of the modem-control byte
  input  lines_t pins_n_i,    // synchronized pins, line order, active-low
  output lines_t lines_o,     // active-high line levels
  output lines_t ctl_n_o      // handshake outputs, control-bit order, active-low
);
  lines_t looped;

  always_comb begin
    looped         = '0;
    looped[LN_CTS] = ctl_i[MC_RTS];
    looped[LN_DSR] = ctl_i[MC_DTR];
    looped[LN_RI]  = ctl_i[MC_OUT1];
    looped[LN_DCD] = ctl_i[MC_OUT2];
  end

  always_comb begin
    if (loop_i) begin
      lines_o = looped;
      ctl_n_o = '1;
    end else begin
      lines_o = ~pins_n_i;
      ctl_n_o = ~ctl_i;
    end
  end
endmodule

// File: rtl/modem_delta_reg.sv
`timescale 1ns/1ps
module modem_delta_reg
  import modem_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lines_t            lines_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] status_o
);
  lines_t lvl_q, lvl_d;
  lines_t delta_q, delta_d;
  lines_t set_flags;

  always_comb begin
    set_flags         = lines_i ^ lvl_q;
    set_flags[LN_RI]  = lvl_q[LN_RI] & ~lines_i[LN_RI];
    lvl_d             = lines_i;
    delta_d           = (rd_i ? '0 : delta_q) | set_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= '0;
      delta_q <= '0;
    end else begin
      lvl_q   <= lvl_d;
      delta_q <= delta_d;
    end
  end

  assign status_o = {lvl_q, delta_q};

  // flags are sticky until a read
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

  // a read with no coinciding change leaves every flag clear
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && lines_i == lvl_q) |=> (delta_q == '0));

  // ring flag cannot appear while the ring level was 0
  assert_ring_trailing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !lvl_q[LN_RI]) |=> (delta_q[LN_RI] == $past(delta_q[LN_RI])));
endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit
  import modem_stat_pkg::*;
#(
  parameter int MCR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MCR_W-1:0]  mcr_i,
  input  logic              ms_irq_en_i,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  input  logic              status_rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              ms_irq_o,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              out1_n_o,
  output logic              out2_n_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  lines_t pins_raw_n, pins_sync_n, lines_lvl, ctl_n;

  always_comb begin
    pins_raw_n         = '1;
    pins_raw_n[LN_CTS] = cts_n_i;
    pins_raw_n[LN_DSR] = dsr_n_i;
    pins_raw_n[LN_RI]  = ri_n_i;
    pins_raw_n[LN_DCD] = dcd_n_i;
  end

  modem_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   (pins_raw_n),
    .q_o   (pins_sync_n)
  );

  modem_line_sel u_sel (
    .loop_i   (mcr_i[MC_LOOP]),
    .ctl_i    (mcr_i[NLINES-1:0]),
    .pins_n_i (pins_sync_n),
    .lines_o  (lines_lvl),
    .ctl_n_o  (ctl_n)
  );

  modem_delta_reg u_delta (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .lines_i  (lines_lvl),
    .rd_i     (status_rd_i),
    .status_o (status_o)
  );

  assign ms_irq_o = ms_irq_en_i & (|status_o[NLINES-1:0]);
  assign dtr_n_o  = ctl_n[MC_DTR];
  assign rts_n_o  = ctl_n[MC_RTS];
  assign out1_n_o = ctl_n[MC_OUT1];
  assign out2_n_o = ctl_n[MC_OUT2];

  // loopback levels track the control bits one clock later
  assert_loop_levels_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    mcr_i[MC_LOOP] |=> (status_o[NLINES+LN_CTS] == $past(mcr_i[MC_RTS])) &&
                       (status_o[NLINES+LN_DSR] == $past(mcr_i[MC_DTR])) &&
                       (status_o[NLINES+LN_RI]  == $past(mcr_i[MC_OUT1])) &&
                       (status_o[NLINES+LN_DCD] == $past(mcr_i[MC_OUT2])));

  // a request always has a pending flag behind it, and is masked by the enable
  assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    ms_irq_o |-> (status_o[NLINES-1:0] != '0) && ms_irq_en_i);
endmodule

// File: tb/modem_status_unit_tb.sv
`timescale 1ns/1ps
module modem_status_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mcr;
  logic       ien;
  logic       cts_n, dsr_n, ri_n, dcd_n;
  logic       rd;
  logic [7:0] status;
  logic       irq;
  logic       dtr_n, rts_n, out1_n, out2_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  modem_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mcr_i(mcr), .ms_irq_en_i(ien),
    .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
    .status_rd_i(rd), .status_o(status), .ms_irq_o(irq),
    .dtr_n_o(dtr_n), .rts_n_o(rts_n), .out1_n_o(out1_n), .out2_n_o(out2_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FIFO-less FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] v);
    rd = 1'b1;
    #1 v = status;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {4'h0, out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic t_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 outputs", outs(), 8'h0F);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    ien = 1'b1;
    cts_n = 1'b0;
    edges(2);
    chk("R3 no early level", status, 8'h00);
    edges(1);
    chk("R3 R2 cts level+flag", status, 8'h11);
    chk("R9 irq raised", {7'h0, irq}, 8'h01);
    read_status(v);
    chk("R8 read value", v, 8'h11);
    chk("R8 flags cleared", status, 8'h10);
    chk("R9 irq removed", {7'h0, irq}, 8'h00);
    dsr_n = 1'b0; dcd_n = 1'b0;
    edges(3);
    chk("R2 R6 dsr/dcd rise", status, 8'hBA);
    read_status(v);
    cts_n = 1'b1;
    edges(3);
    chk("R6 cts fall sets flag", status, 8'hA1);
    read_status(v);
    dsr_n = 1'b1; dcd_n = 1'b1;
    edges(3);
    chk("R6 dsr/dcd fall", status, 8'h0A);
    read_status(v);
    chk("R8 second read levels only", status, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri_n = 1'b0;
    edges(3);
    chk("R7 ring rise no flag", status, 8'h40);
    chk("R7 ring rise no irq", {7'h0, irq}, 8'h00);
    ri_n = 1'b1;
    edges(3);
    chk("R7 ring trailing edge", status, 8'h04);
    chk("R7 irq on trailing", {7'h0, irq}, 8'h01);
    read_status(v);
    chk("R8 ring flag cleared", status, 8'h00);
  endtask

  task automatic t_outputs();
    mcr = 8'h05;
    #1 chk("R5 direct outputs", outs(), 8'h0A);
    edges(1);
    mcr = 8'h00;
    #1 chk("R5 outputs idle", outs(), 8'h0F);
    edges(1);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    mcr = 8'h10;
    edges(1);
    chk("R4 loop entry", status, 8'h00);
    chk("R5 loop outputs high", outs(), 8'h0F);
    cts_n = 1'b0; ri_n = 1'b0;
    edges(4);
    chk("R4 pins ignored", status, 8'h00);
    cts_n = 1'b1; ri_n = 1'b1;
    edges(3);
    mcr = 8'h12;
    edges(1);
    chk("R4 rts to cts", status, 8'h11);
    mcr = 8'h11;
    edges(1);
    chk("R4 dtr to dsr", status, 8'h23);
    read_status(v);
    mcr = 8'h10;
    edges(1);
    read_status(v);
    mcr = 8'h1F;
    edges(1);
    chk("R4 all on", status, 8'hFB);
    chk("R5 loop outputs stay high", outs(), 8'h0F);
    read_status(v);
    mcr = 8'h10;
    edges(1);
    chk("R10 drop all with ring", status, 8'h0F);
    read_status(v);
    mcr = 8'h1B;
    edges(1);
    chk("R4 on without aux1", status, 8'hBB);
    read_status(v);
    mcr = 8'h10;
    edges(1);
    chk("R10 drop all ring idle", status, 8'h0B);
    read_status(v);
    chk("R8 cleared after loop", status, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] v;
    ien = 1'b0;
    mcr = 8'h12;
    edges(1);
    chk("R9 masked flag", status, 8'h11);
    chk("R9 masked irq", {7'h0, irq}, 8'h00);
    ien = 1'b1;
    #1 chk("R9 enable raises irq", {7'h0, irq}, 8'h01);
    read_status(v);
    mcr = 8'h10;
    rd  = 1'b1;
    edges(1);
    rd  = 1'b0;
    chk("R8 change wins over read", status, 8'h01);
    read_status(v);
    mcr = 8'h00;
    edges(1);
    chk("R8 idle after exit", status, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mcr = 8'h00; ien = 1'b0; rd = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    edges(4);
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_pins();
    t_ring();
    t_outputs();
    t_loop();
    t_enable();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule